// File: doc/BRIEF.md
# Serial Memory Command Sequencer

This block sits behind a character receiver and turns a stream of command bytes into operations on a small non-volatile style memory array. It decodes an opcode byte, collects the address and data bytes the opcode calls for, and then reads, streams, programs, erases, clears or fills the array. Program and erase operations start a self-timed cycle. While that cycle runs, only a status query is served.

The array holds 2^ADDR_W bytes. It can be addressed as bytes or as 16-bit words made of an even/odd byte pair, with the high byte at the even address. Response bytes leave on a one-cycle strobe, one per clock. An error output and a busy line, with a separate drive enable and level, report the block's condition. Access protection is decided elsewhere and arrives on the `allow` input. The opcodes that belong to the protection unit make this sequencer step aside until chip select drops.

Top module: `serial_cmd_sequencer`

## Requirements
- R1: After reset no response byte is produced, `err` is low, the busy line is released, every array byte reads FFh, byte addressing is selected, and program enable and busy indication are both off.
- R2: Opcode C8h returns one status byte A0h + 10h·(parity error) + 08h·(instruction error) + 04h·(program cycle running). Both error flags are cleared once that byte has been sent.
- R3: Opcode 86h selects byte addressing and 87h selects word addressing. In byte mode an address takes two bytes, high first, and the low ADDR_W bits are used. In word mode it takes one byte, naming word w at byte addresses 2w (high) and 2w+1 (low).
- R4: Opcode C9h plus an address returns the addressed byte, or in word mode the high byte and then the low byte. Responses start in the cycle after the last address byte is taken and come one per cycle.
- R5: Opcode CBh plus an address streams every byte from that location to the top of the array. Dropping `cs` ends the stream from the next cycle on.
- R6: Opcode C1h plus address and data (one data byte in byte mode, high then low in word mode) stores the data and starts a program cycle of PROG_CYCLES clocks. This happens only if program enable (81h sets it, 82h clears it) and `allow` are both high. Otherwise the array is unchanged and no cycle starts.
- R7: Opcode C0h plus an address, under the same enables as R6, sets the addressed byte to FFh, or the addressed word to FFFFh.
- R8: Clear-all (89h) runs only when 89h arrives twice as consecutive opcodes. It sets every byte to FFh and starts a program cycle. Any other opcode between the two cancels the first one.
- R9: Opcode C3h plus data, coming directly after a single 89h, fills the array: every byte gets the data in byte mode, or every word gets the high/low pair in word mode. Without that preceding 89h the data is consumed and nothing changes.
- R10: After 84h, a program cycle drives the busy line low until the cycle ends and high afterwards. The line is released when the next opcode is accepted. After 85h the line stays released.
- R11: While a program cycle runs, every opcode except C8h is ignored and leaves no trace.
- R12: An opcode outside the recognised set sets the instruction error flag, raises `err`, releases the busy line and ignores all input until `cs` goes low.
- R13: A byte delivered with `rx_perr` high sets the parity error flag and halts the block as in R12.
- R14: Opcodes 88h, 83h, C4h, C5h, CAh and any Dxh are protection commands. They raise no error, and the rest of the frame is ignored until `cs` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select; low aborts the current command and clears a halt |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| rx_perr | input | 1 | The received byte failed its parity check |
| allow | input | 1 | The protection unit permits program/erase |
| tx_valid | output | 1 | Response byte strobe |
| tx_data | output | 8 | Response byte |
| err | output | 1 | Halted on an instruction or parity error |
| busy_oe | output | 1 | Busy line is driven |
| busy_level | output | 1 | Busy line level: 0 busy, 1 ready |

## Verification
The bench aims at the two-entry rules. A lone 89h followed by an unrelated opcode must not clear the array, and a fill must depend on the arming 89h. A design that kept the arm flag across other opcodes would wipe memory, and one that ignored the flag would fill without being asked. It sends commands during a program cycle. A design that acted on them would change the array or start a second cycle, which the per-cycle model exposes. It also checks the busy line across the cycle's last edge and the following opcode, the status byte clearing after it is read, word-mode byte order, and a sequential read cut short by chip select. An error in any of these shows up as a wrong byte or level in a specific cycle.

// File: rtl/scs_pkg.sv
package scs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GATHER,
        ST_SEND,
        ST_PASS,
        ST_HALT
    } seq_state_e;

    typedef enum logic [1:0] {
        BL_OFF,
        BL_LOW,
        BL_HIGH
    } bline_e;

    typedef enum logic [2:0] {
        WR_NONE,
        WR_BYTE,
        WR_WORD,
        WR_FILL_B,
        WR_FILL_W
    } wr_kind_e;

    localparam logic [7:0] OP_NOP     = 8'h80;
    localparam logic [7:0] OP_PE_ON   = 8'h81;
    localparam logic [7:0] OP_PE_OFF  = 8'h82;
    localparam logic [7:0] OP_BSY_ON  = 8'h84;
    localparam logic [7:0] OP_BSY_OFF = 8'h85;
    localparam logic [7:0] OP_ORG_B   = 8'h86;
    localparam logic [7:0] OP_ORG_W   = 8'h87;
    localparam logic [7:0] OP_CLRALL  = 8'h89;
    localparam logic [7:0] OP_ERASE   = 8'hC0;
    localparam logic [7:0] OP_WRITE   = 8'hC1;
    localparam logic [7:0] OP_FILL    = 8'hC3;
    localparam logic [7:0] OP_STAT    = 8'hC8;
    localparam logic [7:0] OP_READ    = 8'hC9;
    localparam logic [7:0] OP_STREAM  = 8'hCB;

    localparam logic [7:0] OP_PROT_A  = 8'h88;
    localparam logic [7:0] OP_PROT_B  = 8'h83;
    localparam logic [7:0] OP_PROT_C  = 8'hC4;
    localparam logic [7:0] OP_PROT_D  = 8'hC5;
    localparam logic [7:0] OP_PROT_E  = 8'hCA;
    localparam logic [3:0] OP_PROT_HI = 4'hD;

endpackage

// File: rtl/scs_array.sv
module scs_array
    import scs_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_kind_e          wr_kind,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];
    logic [ADDR_W-1:0] even_addr;

    assign even_addr = {wr_addr[ADDR_W-1:1], 1'b0};
    assign rd_data   = mem_q[rd_addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else begin
            case (wr_kind)
                WR_BYTE: mem_q[wr_addr] <= wr_data[7:0];
                WR_WORD: begin
                    mem_q[even_addr]        <= wr_data[15:8];
                    mem_q[even_addr | 1'b1] <= wr_data[7:0];
                end
                WR_FILL_B: begin
                    for (int i = 0; i < DEPTH; i++) mem_q[i] <= wr_data[7:0];
                end
                WR_FILL_W: begin
                    for (int i = 0; i < DEPTH; i++)
                        mem_q[i] <= (i % 2 == 0) ? wr_data[15:8] : wr_data[7:0];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/scs_pe_timer.sv
module scs_pe_timer #(
    parameter int PROG_CYCLES = 60000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)            cnt_d = CW'(PROG_CYCLES);
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/serial_cmd_sequencer.sv
module serial_cmd_sequencer
    import scs_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int PROG_CYCLES = 60000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       rx_perr,
    input  logic       allow,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       err,
    output logic       busy_oe,
    output logic       busy_level
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LEFT_W = ADDR_W + 1;

    typedef struct packed {
        seq_state_e        state;
        logic [7:0]        op;
        logic [1:0]        need;
        logic [15:0]       acc;
        logic              pe_en;
        logic              bsy_en;
        logic              word_mode;
        logic              armed;
        logic              fill_ok;
        logic              perr;
        logic              ierr;
        bline_e            bline;
        logic [ADDR_W-1:0] ptr;
        logic [LEFT_W-1:0] left;
        logic              stat_send;
    } seq_regs_t;

    seq_regs_t q, n;

    wr_kind_e          wr_kind;
    logic [ADDR_W-1:0] wr_addr;
    logic [15:0]       wr_data;
    logic [7:0]        rd_data;
    logic              pe_start, pe_busy, pe_done;
    logic              take, pe_ok;
    logic [23:0]       gb;
    logic [ADDR_W-1:0] addr_byte, baddr;
    logic [ADDR_W-2:0] addr_word;
    logic [7:0]        status;

    scs_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_kind (wr_kind),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (q.ptr),
        .rd_data (rd_data)
    );

    scs_pe_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (pe_start),
        .busy  (pe_busy),
        .done  (pe_done)
    );

    assign take      = cs && rx_valid;
    assign pe_ok     = q.pe_en && allow;
    assign gb        = {q.acc, rx_byte};
    assign addr_byte = (q.op == OP_WRITE) ? gb[8 +: ADDR_W] : gb[0 +: ADDR_W];
    assign addr_word = (q.op == OP_WRITE) ? gb[16 +: ADDR_W-1] : gb[0 +: ADDR_W-1];
    assign baddr     = q.word_mode ? {addr_word, 1'b0} : addr_byte;
    assign status    = {3'b101, q.perr, q.ierr, pe_busy, 2'b00};

    always_comb begin
        n        = q;
        wr_kind  = WR_NONE;
        wr_addr  = '0;
        wr_data  = '0;
        pe_start = 1'b0;

        if (pe_done && q.bline == BL_LOW) n.bline = BL_HIGH;

        if (!cs) begin
            n.state     = ST_IDLE;
            n.armed     = 1'b0;
            n.stat_send = 1'b0;
        end else begin
            case (q.state)
                ST_IDLE: begin
                    if (take) begin
                        if (rx_perr) begin
                            n.perr  = 1'b1;
                            n.state = ST_HALT;
                        end else if (!(pe_busy && rx_byte != OP_STAT)) begin
                            if (q.bline == BL_HIGH) n.bline = BL_OFF;
                            n.armed = 1'b0;
                            n.op    = rx_byte;
                            case (rx_byte)
                                OP_NOP:     ;
                                OP_PE_ON:   n.pe_en  = 1'b1;
                                OP_PE_OFF:  n.pe_en  = 1'b0;
                                OP_BSY_ON:  n.bsy_en = 1'b1;
                                OP_BSY_OFF: n.bsy_en = 1'b0;
                                OP_ORG_B, OP_ORG_W: n.word_mode = rx_byte[0];
                                OP_CLRALL: begin
                                    if (q.armed) begin
                                        if (pe_ok) begin
                                            wr_kind  = WR_FILL_B;
                                            wr_data  = 16'hFFFF;
                                            pe_start = 1'b1;
                                            if (q.bsy_en) n.bline = BL_LOW;
                                        end
                                    end else begin
                                        n.armed = 1'b1;
                                    end
                                end
                                OP_FILL: begin
                                    n.fill_ok = q.armed;
                                    n.state   = ST_GATHER;
                                    n.need    = q.word_mode ? 2'd2 : 2'd1;
                                end
                                OP_STAT: begin
                                    n.state     = ST_SEND;
                                    n.left      = LEFT_W'(1);
                                    n.stat_send = 1'b1;
                                end
                                OP_READ, OP_STREAM, OP_ERASE: begin
                                    n.state = ST_GATHER;
                                    n.need  = q.word_mode ? 2'd1 : 2'd2;
                                end
                                OP_WRITE: begin
                                    n.state = ST_GATHER;
                                    n.need  = 2'd3;
                                end
                                OP_PROT_A, OP_PROT_B, OP_PROT_C, OP_PROT_D, OP_PROT_E:
                                    n.state = ST_PASS;
                                default: begin
                                    if (rx_byte[7:4] == OP_PROT_HI) begin
                                        n.state = ST_PASS;
                                    end else begin
                                        n.ierr  = 1'b1;
                                        n.state = ST_HALT;
                                    end
                                end
                            endcase
                        end
                    end
                end

                ST_GATHER: begin
                    if (take) begin
                        if (rx_perr) begin
                            n.perr  = 1'b1;
                            n.state = ST_HALT;
                        end else begin
                            n.acc = gb[15:0];
                            if (q.need != 2'd1) begin
                                n.need = q.need - 1'b1;
                            end else begin
                                n.state = ST_IDLE;
                                case (q.op)
                                    OP_READ: begin
                                        n.state = ST_SEND;
                                        n.ptr   = baddr;
                                        n.left  = q.word_mode ? LEFT_W'(2) : LEFT_W'(1);
                                    end
                                    OP_STREAM: begin
                                        n.state = ST_SEND;
                                        n.ptr   = baddr;
                                        n.left  = LEFT_W'(DEPTH) - LEFT_W'(baddr);
                                    end
                                    OP_ERASE, OP_WRITE: begin
                                        if (pe_ok) begin
                                            wr_kind  = q.word_mode ? WR_WORD : WR_BYTE;
                                            wr_addr  = baddr;
                                            wr_data  = (q.op == OP_ERASE) ? 16'hFFFF :
                                                       (q.word_mode ? gb[15:0] : {8'h00, gb[7:0]});
                                            pe_start = 1'b1;
                                            if (q.bsy_en) n.bline = BL_LOW;
                                        end
                                    end
                                    OP_FILL: begin
                                        if (q.fill_ok && pe_ok) begin
                                            wr_kind  = q.word_mode ? WR_FILL_W : WR_FILL_B;
                                            wr_data  = gb[15:0];
                                            pe_start = 1'b1;
                                            if (q.bsy_en) n.bline = BL_LOW;
                                        end
                                    end
                                    default: ;
                                endcase
                            end
                        end
                    end
                end

                ST_SEND: begin
                    n.ptr  = q.ptr + 1'b1;
                    n.left = q.left - 1'b1;
                    if (q.stat_send) begin
                        n.perr      = 1'b0;
                        n.ierr      = 1'b0;
                        n.stat_send = 1'b0;
                    end
                    if (q.left == LEFT_W'(1)) n.state = ST_IDLE;
                end

                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q           <= '0;
            q.state     <= ST_IDLE;
            q.bline     <= BL_OFF;
        end else begin
            q <= n;
        end
    end

    assign tx_valid   = (q.state == ST_SEND);
    assign tx_data    = q.stat_send ? status : rd_data;
    assign err        = (q.state == ST_HALT);
    assign busy_oe    = (q.bline != BL_OFF) && (q.state != ST_HALT);
    assign busy_level = (q.bline == BL_HIGH);
endmodule

// File: rtl/scs_checker.sv
module scs_checker (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic rx_valid,
    input logic tx_valid,
    input logic err,
    input logic busy_oe,
    input logic busy_level,
    input logic pe_busy
);
    // R12
    halt_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!tx_valid && !busy_oe));

    // R10
    busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_oe && !busy_level) |-> pe_busy);

    // R10
    level_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_level |-> (busy_oe || err));

    // R5
    cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> !tx_valid);

    // R6
    cycle_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pe_busy) |-> $past(cs && rx_valid));

    // R12
    err_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> !err);
endmodule

bind serial_cmd_sequencer scs_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs         (cs),
    .rx_valid   (rx_valid),
    .tx_valid   (tx_valid),
    .err        (err),
    .busy_oe    (busy_oe),
    .busy_level (busy_level),
    .pe_busy    (pe_busy)
);

// File: tb/serial_cmd_sequencer_tb.sv
module serial_cmd_sequencer_tb;
    localparam int AW = 9;
    localparam int PC = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b1, rx_valid = 1'b0, rx_perr = 1'b0, allow = 1'b1;
    logic [7:0] rx_byte = 8'h00;
    logic tx_valid, err, busy_oe, busy_level;
    logic [7:0] tx_data;

    int checks = 0, fails = 0;
    string cur_req = "R1";
    int capq[$];

    always #2.5 clk = ~clk;

    serial_cmd_sequencer #(.ADDR_W(AW), .PROG_CYCLES(PC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_perr(rx_perr), .allow(allow), .tx_valid(tx_valid), .tx_data(tx_data),
        .err(err), .busy_oe(busy_oe), .busy_level(busy_level)
    );

    // behavioural reference: 0 idle, 1 collect, 2 respond, 3 pass, 4 halted
    int mem[DEPTH];
    int st, op, need, cnt, bl;
    int got[$];
    int outq[$];
    bit ewen, ben, wordm, armed, walok, perr, ierr;

    function automatic int m_status();
        return 160 + (perr ? 16 : 0) + (ierr ? 8 : 0) + (cnt > 0 ? 4 : 0);
    endfunction

    task automatic m_start();
        cnt = PC;
        if (ben) bl = 1;
    endtask

    task automatic m_exec();
        int a, ba;
        a  = wordm ? got[0] : (got[0] * 256 + got[1]);
        ba = wordm ? (a % 256) * 2 : a % DEPTH;
        st = 0;
        case (op)
            'hC9: begin
                outq.push_back(mem[ba]);
                if (wordm) outq.push_back(mem[ba + 1]);
                st = 2;
            end
            'hCB: begin
                for (int i = ba; i < DEPTH; i++) outq.push_back(mem[i]);
                st = 2;
            end
            'hC0: if (ewen && allow) begin
                mem[ba] = 255;
                if (wordm) mem[ba + 1] = 255;
                m_start();
            end
            'hC1: if (ewen && allow) begin
                if (wordm) begin mem[ba] = got[1]; mem[ba + 1] = got[2]; end
                else mem[ba] = got[2];
                m_start();
            end
            'hC3: if (walok && ewen && allow) begin
                for (int i = 0; i < DEPTH; i++)
                    mem[i] = wordm ? ((i % 2 == 0) ? got[0] : got[1]) : got[0];
                m_start();
            end
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] = 255;
            st = 0; cnt = 0; bl = 0; ewen = 0; ben = 0; wordm = 0; armed = 0;
            walok = 0; perr = 0; ierr = 0; outq.delete(); got.delete();
        end else begin
            bit busy_now;
            int bl_prev, b;
            busy_now = cnt > 0;
            bl_prev  = bl;
            b        = rx_byte;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0 && bl == 1) bl = 2;
            end
            if (!cs) begin
                st = 0; armed = 0; outq.delete();
            end else if (st == 2) begin
                int h;
                h = outq.pop_front();
                if (h < 0) begin perr = 0; ierr = 0; end
                if (outq.size() == 0) st = 0;
            end else if (st == 0 && rx_valid) begin
                if (rx_perr) begin perr = 1; st = 4; end
                else if (!(busy_now && b != 'hC8)) begin
                    bit was_armed;
                    if (bl_prev == 2) bl = 0;
                    was_armed = armed;
                    armed = 0;
                    op = b;
                    got.delete();
                    if (b == 'h80) ;
                    else if (b == 'h81) ewen = 1;
                    else if (b == 'h82) ewen = 0;
                    else if (b == 'h84) ben = 1;
                    else if (b == 'h85) ben = 0;
                    else if (b == 'h86) wordm = 0;
                    else if (b == 'h87) wordm = 1;
                    else if (b == 'h89) begin
                        if (was_armed) begin
                            if (ewen && allow) begin
                                for (int i = 0; i < DEPTH; i++) mem[i] = 255;
                                m_start();
                            end
                        end else armed = 1;
                    end
                    else if (b == 'hC3) begin walok = was_armed; st = 1; need = wordm ? 2 : 1; end
                    else if (b == 'hC8) begin outq.push_back(-1); st = 2; end
                    else if (b == 'hC9 || b == 'hCB || b == 'hC0) begin st = 1; need = wordm ? 1 : 2; end
                    else if (b == 'hC1) begin st = 1; need = 3; end
                    else if (b == 'h88 || b == 'h83 || b == 'hC4 || b == 'hC5 || b == 'hCA || (b / 16) == 13) st = 3;
                    else begin ierr = 1; st = 4; end
                end
            end else if (st == 1 && rx_valid) begin
                if (rx_perr) begin perr = 1; st = 4; end
                else begin
                    got.push_back(b);
                    if (got.size() == need) m_exec();
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            int ev, ed;
            ev = (st == 2);
            ed = ev ? ((outq[0] < 0) ? m_status() : outq[0]) : 0;
            check(tx_valid == ev, cur_req, "tx_valid", tx_valid, ev);
            if (ev && tx_valid) check(tx_data == ed, cur_req, "tx_data", tx_data, ed);
            check(err == (st == 4), cur_req, "err", err, st == 4);
            check(busy_oe == (bl != 0 && st != 4), cur_req, "busy_oe", busy_oe, bl != 0 && st != 4);
            check(busy_level == (bl == 2), cur_req, "busy_level", busy_level, bl == 2);
            if (tx_valid) capq.push_back(tx_data);
        end
    end

    task automatic put(input logic [7:0] b, input logic pe = 1'b0);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b; rx_perr = pe;
        @(negedge clk);
        rx_valid = 1'b0; rx_perr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_pulse();
        @(negedge clk); cs = 1'b0;
        @(negedge clk); cs = 1'b1;
    endtask

    task automatic expect_bytes(input string req, input int e0, input int e1 = -1);
        check(capq.size() == ((e1 < 0) ? 1 : 2), req, "byte count", capq.size(), (e1 < 0) ? 1 : 2);
        if (capq.size() > 0) check(capq[0] == e0, req, "first byte", capq[0], e0);
        if (e1 >= 0 && capq.size() > 1) check(capq[1] == e1, req, "second byte", capq[1], e1);
        capq.delete();
    endtask

    task automatic rd8(input int a);
        capq.delete();
        put(8'hC9); put(8'(a >> 8)); put(8'(a)); idle(3);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(3);
        // R1 reset state
        cur_req = "R1";
        check(!tx_valid && !err && !busy_oe, "R1", "outputs after reset", {tx_valid, err, busy_oe}, 0);
        rd8(9'h123); expect_bytes("R1", 8'hFF);
        cur_req = "R2"; capq.delete();
        put(8'hC8); idle(3); expect_bytes("R2", 8'hA0);

        // R6 write gating
        cur_req = "R6";
        put(8'hC1); put(8'h00); put(8'h10); put(8'h5A); idle(12);
        rd8(9'h010); expect_bytes("R6", 8'hFF);
        put(8'h81);
        allow = 1'b0;
        put(8'hC1); put(8'h00); put(8'h10); put(8'h5A); idle(12);
        rd8(9'h010); expect_bytes("R6", 8'hFF);
        allow = 1'b1;
        put(8'hC1); put(8'h00); put(8'h10); put(8'h5A); idle(12);
        rd8(9'h010); expect_bytes("R6", 8'h5A);

        // R10 busy line, R11 commands during busy
        cur_req = "R10";
        put(8'h84);
        put(8'hC1); put(8'h01); put(8'hFF); put(8'h33);
        check(busy_oe && !busy_level, "R10", "line low in cycle", {busy_oe, busy_level}, 2);
        cur_req = "R11"; capq.delete();
        put(8'hC9);
        put(8'hC8); idle(2); expect_bytes("R11", 8'hA4);
        idle(6);
        cur_req = "R10";
        check(busy_oe && busy_level, "R10", "line high after cycle", {busy_oe, busy_level}, 3);
        put(8'h80); idle(1);
        check(!busy_oe, "R10", "line released by opcode", busy_oe, 0);
        put(8'h85);
        put(8'hC1); put(8'h00); put(8'h20); put(8'h77); idle(2);
        check(!busy_oe, "R10", "line stays released", busy_oe, 0);
        idle(10);
        rd8(9'h1FF); expect_bytes("R11", 8'h33);

        // R7 erase
        cur_req = "R7";
        put(8'hC0); put(8'h00); put(8'h10); idle(12);
        rd8(9'h010); expect_bytes("R7", 8'hFF);

        // R3 / R4 word mode
        cur_req = "R3"; capq.delete();
        put(8'h87);
        put(8'hC1); put(8'h08); put(8'h12); put(8'h34); idle(12);
        cur_req = "R4"; capq.delete();
        put(8'hC9); put(8'h08); idle(4); expect_bytes("R4", 8'h12, 8'h34);
        cur_req = "R7";
        put(8'hC0); put(8'h00); idle(12);
        put(8'h86);
        cur_req = "R3";
        rd8(9'h010); expect_bytes("R3", 8'h12);
        rd8(9'h011); expect_bytes("R3", 8'h34);

        // R5 sequential read
        cur_req = "R5"; capq.delete();
        put(8'hCB); put(8'h01); put(8'hFE); idle(4);
        expect_bytes("R5", 8'hFF, 8'h33);
        put(8'hCB); put(8'h00); put(8'h00); idle(5);
        cs_pulse(); idle(3);
        check(!tx_valid, "R5", "stream stopped by cs", tx_valid, 0);
        capq.delete();

        // R8 double clear-all
        cur_req = "R8";
        put(8'h89); put(8'h80); put(8'h89); idle(12);
        rd8(9'h1FF); expect_bytes("R8", 8'h33);
        put(8'h89); put(8'h89); idle(12);
        rd8(9'h1FF); expect_bytes("R8", 8'hFF);

        // R9 fill
        cur_req = "R9";
        put(8'hC3); put(8'hAB); idle(12);
        rd8(9'h123); expect_bytes("R9", 8'hFF);
        put(8'h89); put(8'hC3); put(8'h5C); idle(12);
        rd8(9'h123); expect_bytes("R9", 8'h5C);
        put(8'h87); put(8'h89); put(8'hC3); put(8'hC6); put(8'h39); idle(12);
        capq.delete();
        put(8'hC9); put(8'h4D); idle(4); expect_bytes("R9", 8'hC6, 8'h39);
        put(8'h86);

        // R14 protection commands
        cur_req = "R14";
        put(8'hC5); put(8'h12); put(8'hC8); idle(3);
        check(!err && capq.size() == 0, "R14", "frame passed through", err, 0);
        cs_pulse(); capq.delete();
        put(8'hD3); put(8'h00); cs_pulse();
        put(8'hC8); idle(3); expect_bytes("R14", 8'hA0);

        // R12 unknown opcode
        cur_req = "R12";
        put(8'h12); idle(1);
        check(err, "R12", "err raised", err, 1);
        put(8'hC8); idle(3);
        check(capq.size() == 0, "R12", "input ignored while halted", capq.size(), 0);
        cs_pulse(); capq.delete();
        put(8'hC8); idle(3); expect_bytes("R12", 8'hA8);
        cur_req = "R2";
        put(8'hC8); idle(3); expect_bytes("R2", 8'hA0);

        // R13 parity error
        cur_req = "R13";
        put(8'hC9, 1'b1); idle(1);
        check(err, "R13", "err on parity", err, 1);
        cs_pulse(); capq.delete();
        put(8'hC8); idle(3); expect_bytes("R13", 8'hB0);

        idle(5);
        finish_up();
    end
endmodule